// File: doc/BRIEF.md
# Time-Reversal Space-Time Block Formatter

This block prepares the two antenna streams for a two-transmitter, one-receiver time-reversal block code, and it also performs the matching reversal on the receive side. A frame of input is two data blocks, A and B, each of N+1 complex samples with indices 0 to N. In the first timeslot antenna 1 sends A and antenna 2 sends B, both in natural order. In the second timeslot each block goes out reversed in time and complex-conjugated: antenna 1 sends the negated transform of B and antenna 2 sends the transform of A. Over the two slots this gives dual diversity and no gain in capacity. The channel is assumed to stay constant for the whole frame, which is why N has to be chosen short enough.

On the receive side, each second-slot burst of N+1 samples is buffered and then replayed as r3(t) = conj(r2(N - t)). A linear combiner downstream can then treat both bursts with the same channel matrix. Every sample stream uses a valid/ready handshake.

Storage is double-buffered on both paths. One buffer fills while the other drains, so a steady stream never stalls. Every negation saturates, so the most negative code can never wrap to itself.

Top module: `tr_stbc_fmt`

## Requirements
- R1: After reset, tx_out_valid and rx_out_valid are low, and tx_in_ready and rx_in_ready are high.
- R2: One transmit frame is 2(N+1) accepted input samples: the first N+1 form block A and the next N+1 form block B. The frame is emitted as two bursts of N+1 beats each. tx_out_slot is 0 for the first burst and 1 for the second, and tx_out_sof is high exactly on beat 0 of each burst.
- R3: On beat t of the slot-0 burst, antenna 1 carries A[t] and antenna 2 carries B[t], both unchanged.
- R4: On beat t of the slot-1 burst, antenna 1 carries -conj(B[N-t]), which is (-I, +Q) of B[N-t]. Antenna 2 carries conj(A[N-t]), which is (+I, -Q) of A[N-t].
- R5: Samples are two's complement, SW bits per component. A negated component equals the exact negation, except that the most negative code maps to the most positive code. A negated output component never shows the most negative code.
- R6: While an output's valid is high and its ready is low, that output's valid stays high and its data, sof and slot stay unchanged on the next cycle.
- R7: The transmit path accepts a whole second frame while the first is still unread. tx_in_ready goes low only when two complete frames are held and neither has been fully emitted.
- R8: The receive path takes blocks of N+1 samples. On beat t of the replay of a block, rx_out carries (I, -Q) of input sample N-t of that block, and rx_out_sof is high exactly on beat 0.
- R9: The receive path accepts a whole second block while the first is still unread. rx_in_ready goes low only when two blocks are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_in_valid | input | 1 | Transmit sample valid |
| tx_in_ready | output | 1 | Transmit sample accepted |
| tx_in_i | input | SW | Transmit sample, in-phase |
| tx_in_q | input | SW | Transmit sample, quadrature |
| tx_out_valid | output | 1 | Antenna beat valid |
| tx_out_ready | input | 1 | Antenna beat taken |
| tx_out_sof | output | 1 | First beat of a burst |
| tx_out_slot | output | 1 | Timeslot of the burst (0 or 1) |
| a1_i | output | SW | Antenna 1 sample, in-phase |
| a1_q | output | SW | Antenna 1 sample, quadrature |
| a2_i | output | SW | Antenna 2 sample, in-phase |
| a2_q | output | SW | Antenna 2 sample, quadrature |
| rx_in_valid | input | 1 | Received sample valid |
| rx_in_ready | output | 1 | Received sample accepted |
| rx_in_i | input | SW | Received sample, in-phase |
| rx_in_q | input | SW | Received sample, quadrature |
| rx_out_valid | output | 1 | Reversed sample valid |
| rx_out_ready | input | 1 | Reversed sample taken |
| rx_out_sof | output | 1 | First beat of a reversed block |
| rx_out_i | output | SW | Reversed sample, in-phase |
| rx_out_q | output | SW | Reversed sample, quadrature (conjugated) |

## Verification
The assertions watch the framing on every cycle. They count output beats to confirm that start strobes fall every N+1 beats and that the slot alternates. They also confirm that stalled outputs hold steady and that no negated component ever shows the most negative code.

The values themselves can only be shown by the bench's scenarios. These cover the index reversal, which block reaches which antenna, the sign of each component, and the saturation at the extreme code. The bench also shows the ping-pong depth: input ready falls only after two whole frames or blocks are held while the consumer is stalled.

// File: rtl/tr_stbc_fmt.sv
module tr_stbc_fmt #(
  parameter int N_LAST = 15,
  parameter int SW     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [SW-1:0] tx_in_i,
  input  logic [SW-1:0] tx_in_q,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic          tx_out_sof,
  output logic          tx_out_slot,
  output logic [SW-1:0] a1_i,
  output logic [SW-1:0] a1_q,
  output logic [SW-1:0] a2_i,
  output logic [SW-1:0] a2_q,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [SW-1:0] rx_in_i,
  input  logic [SW-1:0] rx_in_q,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic          rx_out_sof,
  output logic [SW-1:0] rx_out_i,
  output logic [SW-1:0] rx_out_q
);
  localparam int D  = N_LAST + 1;
  localparam int RW = $clog2(D);
  localparam int TW = RW + 1;
  localparam logic [RW-1:0] LAST  = RW'(N_LAST);
  localparam logic [RW-1:0] RONE  = RW'(1);
  localparam logic [TW-1:0] TLAST = TW'(2 * D - 1);
  localparam logic [TW-1:0] TONE  = TW'(1);
  localparam logic [TW-1:0] DT    = TW'(D);
  localparam logic [SW-1:0] SMIN  = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] SMAX  = ~SMIN;
  localparam logic [SW-1:0] SONE  = SW'(1);

  function automatic logic [SW-1:0] neg_sat(input logic [SW-1:0] v);
    return (v == SMIN) ? SMAX : (~v + SONE);
  endfunction

  // transmit path: two frame buffers, each holding block A then block B
  logic [SW-1:0] tm_i [2][2*D];
  logic [SW-1:0] tm_q [2][2*D];
  logic [1:0]    tx_full;
  logic          tx_wb, tx_rb, tx_ph;
  logic [TW-1:0] tx_widx;
  logic [RW-1:0] tx_ridx;
  logic          tx_wr, tx_rd;

  assign tx_in_ready  = !tx_full[tx_wb];
  assign tx_out_valid = tx_full[tx_rb];
  assign tx_wr        = tx_in_valid && tx_in_ready;
  assign tx_rd        = tx_out_valid && tx_out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= '0;
      tx_wb   <= 1'b0;
      tx_rb   <= 1'b0;
      tx_ph   <= 1'b0;
      tx_widx <= '0;
      tx_ridx <= '0;
    end else begin
      if (tx_wr) begin
        if (tx_widx == TLAST) begin
          tx_widx        <= '0;
          tx_full[tx_wb] <= 1'b1;
          tx_wb          <= ~tx_wb;
        end else begin
          tx_widx <= tx_widx + TONE;
        end
      end
      if (tx_rd) begin
        if (tx_ridx == LAST) begin
          tx_ridx <= '0;
          if (tx_ph) begin
            tx_ph          <= 1'b0;
            tx_full[tx_rb] <= 1'b0;
            tx_rb          <= ~tx_rb;
          end else begin
            tx_ph <= 1'b1;
          end
        end else begin
          tx_ridx <= tx_ridx + RONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_wr) begin
      tm_i[tx_wb][tx_widx] <= tx_in_i;
      tm_q[tx_wb][tx_widx] <= tx_in_q;
    end
  end

  logic [RW-1:0] tx_sel;
  logic [TW-1:0] slot_a, slot_b;
  logic [SW-1:0] ai, aq, bi, bq;

  assign tx_sel = tx_ph ? (LAST - tx_ridx) : tx_ridx;
  assign slot_a = {1'b0, tx_sel};
  assign slot_b = slot_a + DT;
  assign ai     = tm_i[tx_rb][slot_a];
  assign aq     = tm_q[tx_rb][slot_a];
  assign bi     = tm_i[tx_rb][slot_b];
  assign bq     = tm_q[tx_rb][slot_b];

  assign a1_i        = tx_ph ? neg_sat(bi) : ai;
  assign a1_q        = tx_ph ? bq          : aq;
  assign a2_i        = tx_ph ? ai          : bi;
  assign a2_q        = tx_ph ? neg_sat(aq) : bq;
  assign tx_out_sof  = (tx_ridx == '0);
  assign tx_out_slot = tx_ph;

  // receive path: two block buffers, replayed in descending order
  logic [SW-1:0] rm_i [2][D];
  logic [SW-1:0] rm_q [2][D];
  logic [1:0]    rx_full;
  logic          rx_wb, rx_rb;
  logic [RW-1:0] rx_widx, rx_ridx, rx_sel;
  logic          rx_wr, rx_rd;

  assign rx_in_ready  = !rx_full[rx_wb];
  assign rx_out_valid = rx_full[rx_rb];
  assign rx_wr        = rx_in_valid && rx_in_ready;
  assign rx_rd        = rx_out_valid && rx_out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= '0;
      rx_wb   <= 1'b0;
      rx_rb   <= 1'b0;
      rx_widx <= '0;
      rx_ridx <= '0;
    end else begin
      if (rx_wr) begin
        if (rx_widx == LAST) begin
          rx_widx        <= '0;
          rx_full[rx_wb] <= 1'b1;
          rx_wb          <= ~rx_wb;
        end else begin
          rx_widx <= rx_widx + RONE;
        end
      end
      if (rx_rd) begin
        if (rx_ridx == LAST) begin
          rx_ridx        <= '0;
          rx_full[rx_rb] <= 1'b0;
          rx_rb          <= ~rx_rb;
        end else begin
          rx_ridx <= rx_ridx + RONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rx_wr) begin
      rm_i[rx_wb][rx_widx] <= rx_in_i;
      rm_q[rx_wb][rx_widx] <= rx_in_q;
    end
  end

  assign rx_sel     = LAST - rx_ridx;
  assign rx_out_i   = rm_i[rx_rb][rx_sel];
  assign rx_out_q   = neg_sat(rm_q[rx_rb][rx_sel]);
  assign rx_out_sof = (rx_ridx == '0);
endmodule

// File: rtl/tr_stbc_fmt_chk.sv
module tr_stbc_fmt_chk #(
  parameter int N_LAST = 15,
  parameter int SW     = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic          tx_out_sof,
  input logic          tx_out_slot,
  input logic [SW-1:0] a1_i,
  input logic [SW-1:0] a1_q,
  input logic [SW-1:0] a2_i,
  input logic [SW-1:0] a2_q,
  input logic          rx_out_valid,
  input logic          rx_out_ready,
  input logic          rx_out_sof,
  input logic [SW-1:0] rx_out_i,
  input logic [SW-1:0] rx_out_q
);
  localparam int CW = $clog2(N_LAST + 1) + 1;
  localparam logic [CW-1:0] CLAST = CW'(N_LAST);
  localparam logic [CW-1:0] CONE  = CW'(1);
  localparam logic [SW-1:0] SMIN  = {1'b1, {(SW-1){1'b0}}};

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          exp_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt   <= '0;
      rx_cnt   <= '0;
      exp_slot <= 1'b0;
    end else begin
      if (tx_out_valid && tx_out_ready) begin
        if (tx_cnt == CLAST) begin
          tx_cnt   <= '0;
          exp_slot <= ~exp_slot;
        end else begin
          tx_cnt <= tx_cnt + CONE;
        end
      end
      if (rx_out_valid && rx_out_ready)
        rx_cnt <= (rx_cnt == CLAST) ? '0 : rx_cnt + CONE;
    end
  end

  a_r2_tx_sof: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid |-> (tx_out_sof == (tx_cnt == '0)));
  a_r2_tx_slot: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid |-> (tx_out_slot == exp_slot));
  a_r8_rx_sof: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> (rx_out_sof == (rx_cnt == '0)));
  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(a1_i) && $stable(a1_q)
      && $stable(a2_i) && $stable(a2_q) && $stable(tx_out_sof) && $stable(tx_out_slot)));
  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && !rx_out_ready) |=> (rx_out_valid && $stable(rx_out_i)
      && $stable(rx_out_q) && $stable(rx_out_sof)));
  a_r5_tx_no_min: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && tx_out_slot) |-> (a1_i != SMIN && a2_q != SMIN));
  a_r5_rx_no_min: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> (rx_out_q != SMIN));
endmodule

bind tr_stbc_fmt tr_stbc_fmt_chk #(.N_LAST(N_LAST), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_out_sof(tx_out_sof), .tx_out_slot(tx_out_slot),
  .a1_i(a1_i), .a1_q(a1_q), .a2_i(a2_i), .a2_q(a2_q),
  .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
  .rx_out_sof(rx_out_sof), .rx_out_i(rx_out_i), .rx_out_q(rx_out_q)
);

// File: tb/sim_tr_stbc_fmt.sv
module sim_tr_stbc_fmt;
  localparam int N_LAST = 5;
  localparam int SW     = 8;
  localparam int D      = N_LAST + 1;
  localparam int VMIN   = -(2 ** (SW - 1));
  localparam int VMAX   = 2 ** (SW - 1) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          tx_in_valid = 1'b0, tx_in_ready;
  logic [SW-1:0] tx_in_i = '0, tx_in_q = '0;
  logic          tx_out_valid, tx_out_ready = 1'b0, tx_out_sof, tx_out_slot;
  logic [SW-1:0] a1_i, a1_q, a2_i, a2_q;
  logic          rx_in_valid = 1'b0, rx_in_ready;
  logic [SW-1:0] rx_in_i = '0, rx_in_q = '0;
  logic          rx_out_valid, rx_out_ready = 1'b0, rx_out_sof;
  logic [SW-1:0] rx_out_i, rx_out_q;

  tr_stbc_fmt #(.N_LAST(N_LAST), .SW(SW)) u0 (.*);

  typedef struct {
    int a1i, a1q, a2i, a2q;
    bit sof, slot, sat;
  } tx_item_t;
  typedef struct {
    int i, q;
    bit sof, sat;
  } rx_item_t;

  tx_item_t txq[$];
  rx_item_t rxq[$];
  int errors = 0;
  int checks = 0;
  bit tx_hold = 0, rx_hold = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int sneg(input int v);
    return (v == VMIN) ? VMAX : -v;
  endfunction

  task automatic drive_tx(input int i, input int q);
    @(negedge clk);
    tx_in_valid = 1'b1;
    tx_in_i = i[SW-1:0];
    tx_in_q = q[SW-1:0];
    #2;
    while (!tx_in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
  endtask

  task automatic drive_rx(input int i, input int q);
    @(negedge clk);
    rx_in_valid = 1'b1;
    rx_in_i = i[SW-1:0];
    rx_in_q = q[SW-1:0];
    #2;
    while (!rx_in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
  endtask

  task automatic send_frame(input int ai[D], input int aq[D], input int bi[D], input int bq[D]);
    for (int t = 0; t < D; t++) begin
      tx_item_t it;
      it.a1i = ai[t]; it.a1q = aq[t]; it.a2i = bi[t]; it.a2q = bq[t];
      it.sof = (t == 0); it.slot = 1'b0; it.sat = 1'b0;
      txq.push_back(it);
    end
    for (int t = 0; t < D; t++) begin
      tx_item_t it;
      it.a1i = sneg(bi[N_LAST-t]); it.a1q = bq[N_LAST-t];
      it.a2i = ai[N_LAST-t];       it.a2q = sneg(aq[N_LAST-t]);
      it.sof = (t == 0); it.slot = 1'b1;
      it.sat = (bi[N_LAST-t] == VMIN) || (aq[N_LAST-t] == VMIN);
      txq.push_back(it);
    end
    for (int t = 0; t < D; t++) drive_tx(ai[t], aq[t]);
    for (int t = 0; t < D; t++) drive_tx(bi[t], bq[t]);
    @(negedge clk);
    tx_in_valid = 1'b0;
  endtask

  task automatic send_block(input int ri[D], input int rq[D]);
    for (int t = 0; t < D; t++) begin
      rx_item_t it;
      it.i = ri[N_LAST-t];
      it.q = sneg(rq[N_LAST-t]);
      it.sof = (t == 0);
      it.sat = (rq[N_LAST-t] == VMIN);
      rxq.push_back(it);
    end
    for (int t = 0; t < D; t++) drive_rx(ri[t], rq[t]);
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  // transmit monitor
  int tx_cyc = 0;
  bit tx_stall = 0;
  logic [4*SW+1:0] tx_snap;
  always @(negedge clk) begin
    if (rst_n) begin
      tx_cyc++;
      tx_out_ready = !tx_hold && (tx_cyc % 5 != 2);
      #1;
      if (tx_stall)
        chk(tx_out_valid && tx_snap == {a1_i, a1_q, a2_i, a2_q, tx_out_sof, tx_out_slot},
            "R6", "tx held beat changed", int'(tx_out_valid), 1);
      if (tx_out_valid && tx_out_ready) begin
        if (txq.size() == 0) chk(0, "R2", "unexpected tx beat", 1, 0);
        else begin
          tx_item_t e;
          string tg;
          e = txq.pop_front();
          tg = e.sat ? "R5" : (e.slot ? "R4" : "R3");
          chk(int'(tx_out_sof) == int'(e.sof), "R2", "tx sof", int'(tx_out_sof), int'(e.sof));
          chk(int'(tx_out_slot) == int'(e.slot), "R2", "tx slot", int'(tx_out_slot), int'(e.slot));
          chk(int'($signed(a1_i)) == e.a1i, tg, "ant1 I", int'($signed(a1_i)), e.a1i);
          chk(int'($signed(a1_q)) == e.a1q, tg, "ant1 Q", int'($signed(a1_q)), e.a1q);
          chk(int'($signed(a2_i)) == e.a2i, tg, "ant2 I", int'($signed(a2_i)), e.a2i);
          chk(int'($signed(a2_q)) == e.a2q, tg, "ant2 Q", int'($signed(a2_q)), e.a2q);
        end
      end
      tx_stall = tx_out_valid && !tx_out_ready;
      tx_snap = {a1_i, a1_q, a2_i, a2_q, tx_out_sof, tx_out_slot};
    end
  end

  // receive monitor
  int rx_cyc = 0;
  bit rx_stall = 0;
  logic [2*SW:0] rx_snap;
  always @(negedge clk) begin
    if (rst_n) begin
      rx_cyc++;
      rx_out_ready = !rx_hold && (rx_cyc % 3 != 1);
      #1;
      if (rx_stall)
        chk(rx_out_valid && rx_snap == {rx_out_i, rx_out_q, rx_out_sof},
            "R6", "rx held beat changed", int'(rx_out_valid), 1);
      if (rx_out_valid && rx_out_ready) begin
        if (rxq.size() == 0) chk(0, "R8", "unexpected rx beat", 1, 0);
        else begin
          rx_item_t e;
          string tg;
          e = rxq.pop_front();
          tg = e.sat ? "R5" : "R8";
          chk(int'(rx_out_sof) == int'(e.sof), "R8", "rx sof", int'(rx_out_sof), int'(e.sof));
          chk(int'($signed(rx_out_i)) == e.i, "R8", "rx I", int'($signed(rx_out_i)), e.i);
          chk(int'($signed(rx_out_q)) == e.q, tg, "rx Q", int'($signed(rx_out_q)), e.q);
        end
      end
      rx_stall = rx_out_valid && !rx_out_ready;
      rx_snap = {rx_out_i, rx_out_q, rx_out_sof};
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    finish_run();
  end

  task automatic drain();
    while (txq.size() != 0 || rxq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int ai[D], aq[D], bi[D], bq[D];
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    chk(tx_out_valid == 1'b0, "R1", "tx_out_valid", int'(tx_out_valid), 0);
    chk(rx_out_valid == 1'b0, "R1", "rx_out_valid", int'(rx_out_valid), 0);
    chk(tx_in_ready == 1'b1, "R1", "tx_in_ready", int'(tx_in_ready), 1);
    chk(rx_in_ready == 1'b1, "R1", "rx_in_ready", int'(rx_in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // ramp frames, then a frame full of extreme codes
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < D; k++) begin
        ai[k] = ((f * 37 + k * 5) % 200) - 100;
        aq[k] = ((f * 23 + k * 11 + 7) % 200) - 100;
        bi[k] = ((f * 17 + k * 13 + 3) % 200) - 100;
        bq[k] = ((f * 29 + k * 3 + 50) % 200) - 100;
      end
      if (f == 2) begin
        ai[0] = VMIN; aq[0] = VMIN; aq[2] = VMAX;
        bi[N_LAST] = VMIN; bi[3] = VMAX; bq[1] = VMIN;
      end
      send_frame(ai, aq, bi, bq);
    end
    drain();

    // R7: two frames held while the consumer is stalled
    tx_hold = 1;
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < D; k++) begin
        ai[k] = k + f * 10; aq[k] = -k - 1; bi[k] = 40 - k; bq[k] = k * 7 - f;
      end
      send_frame(ai, aq, bi, bq);
    end
    @(negedge clk);
    #2;
    chk(tx_in_ready == 1'b0, "R7", "tx_in_ready with two frames held", int'(tx_in_ready), 0);
    chk(tx_out_valid == 1'b1, "R7", "tx_out_valid with two frames held", int'(tx_out_valid), 1);
    tx_hold = 0;
    drain();

    // receive blocks, one with extreme codes
    for (int b = 0; b < 3; b++) begin
      for (int k = 0; k < D; k++) begin
        ai[k] = ((b * 41 + k * 9) % 180) - 90;
        aq[k] = ((b * 19 + k * 14 + 5) % 180) - 90;
      end
      if (b == 1) begin
        aq[0] = VMIN; aq[N_LAST] = VMAX; ai[2] = VMIN; aq[3] = VMIN;
      end
      send_block(ai, aq);
    end
    drain();

    // R9: two blocks held while the consumer is stalled
    rx_hold = 1;
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < D; k++) begin
        ai[k] = k * 3 + b; aq[k] = 60 - k * 4;
      end
      send_block(ai, aq);
    end
    @(negedge clk);
    #2;
    chk(rx_in_ready == 1'b0, "R9", "rx_in_ready with two blocks held", int'(rx_in_ready), 0);
    chk(rx_out_valid == 1'b1, "R9", "rx_out_valid with two blocks held", int'(rx_out_valid), 1);
    rx_hold = 0;
    drain();

    finish_run();
  end
endmodule